// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits between a host register bus and the shift engine of an SPI master. It holds two byte-wide queues: a transmit queue that software fills and the engine drains, and a receive queue that the engine fills and software drains. It also builds the status word software polls, the interrupt mask, and the interrupt line. The shift engine is a separate block. It sees a "byte available" flag with the head byte and a pop strobe on the transmit side, a push strobe with a byte on the receive side, and it pulses a done strobe when a transaction finishes.

The status word mixes two kinds of content. Some of it is live: the occupancy of each queue and the level flags derived from it (transmit empty, transmit not full, receive full, receive not empty). The rest is sticky and is cleared by writing 1: a transmit-below-threshold event, a receive-above-threshold event, and a done event. Both thresholds are programmable in the mode word. The interrupt line is high when any status bit that the mask selects is set. When the enable bit is cleared, both queues are flushed and the sticky events are cleared.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset the mode word reads 0x00000000, the mask reads 0x00000000, the status word reads 0x00008100 (transmit empty and transmit not full set), and `irq`, `ctl_en` and `ctl_loop` are 0.
- R2: The mode word at byte offset 0x00 stores enable at bit 31, loopback at bit 30, a 6-bit transmit threshold at bits 13:8 and a 5-bit receive threshold at bits 4:0. These read back at the same positions, all other bits read 0, and enable and loopback drive `ctl_en` and `ctl_loop`.
- R3: A write to offset 0x10 pushes `bus_wdata[7:0]` into the 32-entry transmit queue. A push to a full queue is ignored. `eng_tx_valid` is high when enabled and the queue is not empty, `eng_tx_data` shows the oldest byte, and `eng_tx_pop` removes it, so bytes leave in the order they were written.
- R4: `eng_rx_push` stores `eng_rx_data` into the 32-entry receive queue; a push to a full queue is ignored. A read of offset 0x14 returns the oldest byte in bits 7:0, with the upper bits 0, and removes it. A read of an empty queue returns 0 and changes nothing.
- R5: The status word at offset 0x04 holds the receive count at bits 29:24 and the transmit count at bits 21:16. It also holds four live flags: transmit empty at bit 15, receive full at bit 12, receive not empty at bit 9 and transmit not full at bit 8.
- R6: Sticky bit 13 sets when the receive count goes from not above to above the receive threshold. Sticky bit 11 sets when the transmit count goes from not below to below the transmit threshold, and enabling with an empty queue counts as such a change.
- R7: A pulse on `eng_done` while enabled sets sticky bit 14.
- R8: Writing the status word clears each sticky bit (14, 13, 11) where the written data has a 1. Zeros leave the bits alone, and the live fields are unaffected.
- R9: The mask at offset 0x08 stores bits 15:8, with all other bits reading 0. `irq` is 1 exactly when the status word ANDed with the mask is non-zero.
- R10: While enable is 0, both queues are held empty, the sticky bits are held clear, and bus pushes, engine pushes and done pulses have no effect.
- R11: Reads of the transmit port 0x10 or of an unmapped offset return 0. Writes to unmapped offsets or to the receive port change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request |
| ctl_en | output | 1 | Controller enable to the shift engine |
| ctl_loop | output | 1 | Loopback select to the shift engine |
| eng_tx_valid | output | 1 | Transmit byte available |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_done | input | 1 | Transaction-done pulse |

## Verification
The bench overfills both queues by one entry. A design that wrapped its count would report a small occupancy and drop old data, and a design that overwrote its storage would return a wrong byte when the queue is drained. It reads the empty receive port, where a broken underflow guard would return stale data or drive the count negative. It clears sticky bits one at a time while their cause still holds, which exposes a design that sets them on the level rather than the edge, and it writes zeros to check that no bit is cleared by accident. It disables and then pushes and pulses done, so a design that failed to gate these inputs would show non-zero counts or a done event afterwards. Random traffic mixed with threshold changes then compares every status read and the interrupt against a queue model.

// File: rtl/spi_fifo_evt_pkg.sv
package spi_fifo_evt_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TXP  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RXP  = 6'h14;

    localparam int MD_EN     = 31;
    localparam int MD_LOOP   = 30;
    localparam int TXTH_LSB  = 8;
    localparam int TXTH_W    = 6;
    localparam int RXTH_LSB  = 0;
    localparam int RXTH_W    = 5;

    localparam int RXCNT_LSB = 24;
    localparam int TXCNT_LSB = 16;
    localparam int CNTF_W    = 6;

    localparam int FL_TXE = 15;
    localparam int FL_DON = 14;
    localparam int FL_RXT = 13;
    localparam int FL_RXF = 12;
    localparam int FL_TXT = 11;
    localparam int FL_RNE = 9;
    localparam int FL_TNF = 8;

    localparam int MSK_LSB = 8;
    localparam int MSK_W   = 8;

    typedef struct packed {
        logic              en;
        logic              loop;
        logic [TXTH_W-1:0] tx_th;
        logic [RXTH_W-1:0] rx_th;
    } mode_t;

endpackage

// File: rtl/spi_fifo_evt_queue.sv
module spi_fifo_evt_queue #(
    parameter int DEPTH  = 32,
    parameter int DW     = 8,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } qst_t;

    qst_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        push_ok = push && !flush && (st_q.cnt < FULLC);
        pop_ok  = pop && !flush && (st_q.cnt != '0);
        if (push_ok) begin
            st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[st_q.wptr] <= push_data;
        end
    end

    assign head  = mem_q[st_q.rptr];
    assign count = st_q.cnt;

    // R3 / R4: occupancy never exceeds the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULLC);

    // R3: a lone push into a full queue leaves the count unchanged
    p_full_push_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULLC && push && !pop && !flush) |=> $stable(st_q.cnt));

    // R4: a lone pop from an empty queue leaves the count unchanged
    p_empty_pop_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && pop && !push) |=> (st_q.cnt == '0));

    // R10: flush empties the queue on the next cycle
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0));

endmodule

// File: rtl/spi_fifo_evt_regs.sv
module spi_fifo_evt_regs
    import spi_fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [CW-1:0]     tx_cnt,
    input  logic [CW-1:0]     rx_cnt,
    input  logic [DW-1:0]     rx_head,
    input  logic              eng_done,
    output logic              en_o,
    output logic              loop_o,
    output logic              tx_push,
    output logic              rx_pop,
    output logic              flush,
    output logic              irq
);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        mode_t            mode;
        logic [MSK_W-1:0] mask;
        logic             don;
        logic             rxt;
        logic             txt;
        logic             rx_hi;
        logic             tx_lo;
    } rst_t;

    rst_t st_d, st_q;
    logic wr_hit, rd_hit, wr_stat;
    logic rx_hi, tx_lo;
    logic [REG_W-1:0] stat_view, mode_view, mask_view;

    always_comb begin
        wr_hit  = bus_sel && bus_wr;
        rd_hit  = bus_sel && !bus_wr;
        wr_stat = wr_hit && (bus_addr == OFS_STAT);
        rx_hi   = st_q.mode.en && ({{(CW-RXTH_W){1'b0}}, st_q.mode.rx_th} < rx_cnt);
        tx_lo   = st_q.mode.en && (tx_cnt < CW'(st_q.mode.tx_th));

        stat_view = '0;
        stat_view[RXCNT_LSB +: CNTF_W] = CNTF_W'(rx_cnt);
        stat_view[TXCNT_LSB +: CNTF_W] = CNTF_W'(tx_cnt);
        stat_view[FL_TXE] = (tx_cnt == '0);
        stat_view[FL_DON] = st_q.don;
        stat_view[FL_RXT] = st_q.rxt;
        stat_view[FL_RXF] = (rx_cnt == FULLC);
        stat_view[FL_TXT] = st_q.txt;
        stat_view[FL_RNE] = (rx_cnt != '0);
        stat_view[FL_TNF] = (tx_cnt != FULLC);

        mode_view = '0;
        mode_view[MD_EN]   = st_q.mode.en;
        mode_view[MD_LOOP] = st_q.mode.loop;
        mode_view[TXTH_LSB +: TXTH_W] = st_q.mode.tx_th;
        mode_view[RXTH_LSB +: RXTH_W] = st_q.mode.rx_th;

        mask_view = '0;
        mask_view[MSK_LSB +: MSK_W] = st_q.mask;

        st_d       = st_q;
        st_d.rx_hi = rx_hi;
        st_d.tx_lo = tx_lo;

        if (wr_stat) begin
            if (bus_wdata[FL_DON]) st_d.don = 1'b0;
            if (bus_wdata[FL_RXT]) st_d.rxt = 1'b0;
            if (bus_wdata[FL_TXT]) st_d.txt = 1'b0;
        end
        if (rx_hi && !st_q.rx_hi) st_d.rxt = 1'b1;
        if (tx_lo && !st_q.tx_lo) st_d.txt = 1'b1;
        if (eng_done && st_q.mode.en) st_d.don = 1'b1;
        if (!st_q.mode.en) begin
            st_d.don = 1'b0;
            st_d.rxt = 1'b0;
            st_d.txt = 1'b0;
        end

        if (wr_hit && bus_addr == OFS_MODE) begin
            st_d.mode.en    = bus_wdata[MD_EN];
            st_d.mode.loop  = bus_wdata[MD_LOOP];
            st_d.mode.tx_th = bus_wdata[TXTH_LSB +: TXTH_W];
            st_d.mode.rx_th = bus_wdata[RXTH_LSB +: RXTH_W];
        end
        if (wr_hit && bus_addr == OFS_MASK) begin
            st_d.mask = bus_wdata[MSK_LSB +: MSK_W];
        end

        tx_push = wr_hit && (bus_addr == OFS_TXP);
        rx_pop  = rd_hit && (bus_addr == OFS_RXP);

        bus_rdata = '0;
        if (rd_hit) begin
            case (bus_addr)
                OFS_MODE: bus_rdata = mode_view;
                OFS_STAT: bus_rdata = stat_view;
                OFS_MASK: bus_rdata = mask_view;
                OFS_RXP:  bus_rdata = (rx_cnt == '0) ? '0 : REG_W'(rx_head);
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.mode.en;
    assign loop_o = st_q.mode.loop;
    assign flush  = !st_q.mode.en;
    assign irq    = |(stat_view & mask_view);

    // R9: an all-zero mask keeps the interrupt low
    p_mask_zero_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask == '0) |-> !irq);

    // R7: done while enabled is recorded
    p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && st_q.mode.en) |=> st_q.don);

    // R8: write-1 clears done when no new done arrives
    p_w1c_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata[FL_DON] && !eng_done) |=> !st_q.don);

    // R6: receive threshold event holds until cleared or disabled
    p_rxt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rxt && st_q.mode.en && !(wr_stat && bus_wdata[FL_RXT])) |=> st_q.rxt);

    // R10: sticky events are clear one cycle into a disabled period
    p_disabled_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode.en |=> !(st_q.don || st_q.rxt || st_q.txt));

endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
    import spi_fifo_evt_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              ctl_en,
    output logic              ctl_loop,
    output logic              eng_tx_valid,
    output logic [DW-1:0]     eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [DW-1:0]     eng_rx_data,
    input  logic              eng_done
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DW-1:0] rx_head;
    logic tx_push, rx_pop, flush;

    spi_fifo_evt_regs #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .rx_head   (rx_head),
        .eng_done  (eng_done),
        .en_o      (ctl_en),
        .loop_o    (ctl_loop),
        .tx_push   (tx_push),
        .rx_pop    (rx_pop),
        .flush     (flush),
        .irq       (irq)
    );

    spi_fifo_evt_queue #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) txq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (tx_push),
        .push_data (bus_wdata[DW-1:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .count     (tx_cnt)
    );

    spi_fifo_evt_queue #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_cnt)
    );

    assign eng_tx_valid = ctl_en && (tx_cnt != '0);

    // R3: the engine is never offered a byte while disabled
    p_tx_valid_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_valid |-> ctl_en);

    // R10: counts are zero one cycle into a disabled period
    p_disabled_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (tx_cnt == '0 && rx_cnt == '0));

endmodule

// File: tb/spi_fifo_evt_tb_top.sv
module spi_fifo_evt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, ctl_en, ctl_loop, eng_tx_valid;
    logic [7:0] eng_tx_data;
    logic eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_done = 1'b0;
    logic [7:0] eng_rx_data = '0;

    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_evt dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .ctl_en(ctl_en), .ctl_loop(ctl_loop),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_done(eng_done)
    );

    // bench model
    logic [7:0] m_tx[$];
    logic [7:0] m_rx[$];
    bit m_en = 0, m_don = 0, m_rxt = 0, m_txt = 0, m_rxhi = 0, m_txlo = 0;
    int m_txth = 0, m_rxth = 0;
    logic [7:0] m_mask = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic void m_eval();
        bit hi, lo;
        hi = m_en && (m_rx.size() > m_rxth);
        lo = m_en && (m_tx.size() < m_txth);
        if (hi && !m_rxhi) m_rxt = 1;
        if (lo && !m_txlo) m_txt = 1;
        m_rxhi = hi;
        m_txlo = lo;
    endfunction

    function automatic logic [31:0] exp_stat();
        logic [31:0] v = '0;
        v[29:24] = 6'(m_rx.size());
        v[21:16] = 6'(m_tx.size());
        v[15] = (m_tx.size() == 0);
        v[14] = m_don;
        v[13] = m_rxt;
        v[12] = (m_rx.size() == DEPTH);
        v[11] = m_txt;
        v[9]  = (m_rx.size() != 0);
        v[8]  = (m_tx.size() != DEPTH);
        return v;
    endfunction

    function automatic logic exp_irq();
        logic [31:0] s = exp_stat();
        return |(s[15:8] & m_mask);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic mode_wr(input logic [31:0] d);
        wr(6'h00, d);
        m_en = d[31];
        m_txth = int'(d[13:8]);
        m_rxth = int'(d[4:0]);
        if (!m_en) begin
            m_tx.delete(); m_rx.delete();
            m_don = 0; m_rxt = 0; m_txt = 0; m_rxhi = 0; m_txlo = 0;
        end
        m_eval();
    endtask

    task automatic tx_push(input logic [7:0] b);
        wr(6'h10, {24'hABCDEF, b});
        if (m_en && m_tx.size() < DEPTH) m_tx.push_back(b);
        m_eval();
    endtask

    task automatic eng_pop(input string req);
        @(negedge clk);
        #1;
        if (m_tx.size() != 0) begin
            check(req, {23'd0, eng_tx_valid, eng_tx_data}, {23'd0, 1'b1, m_tx[0]});
        end else begin
            check(req, {31'd0, eng_tx_valid}, 32'd0);
        end
        eng_tx_pop = 1;
        @(negedge clk);
        eng_tx_pop = 0;
        if (m_en && m_tx.size() != 0) void'(m_tx.pop_front());
        m_eval();
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_push = 1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 0;
        if (m_en && m_rx.size() < DEPTH) m_rx.push_back(b);
        m_eval();
    endtask

    task automatic pulse_done();
        @(negedge clk);
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
        if (m_en) m_don = 1;
        m_eval();
    endtask

    task automatic rx_read(input string req);
        logic [31:0] d;
        logic [31:0] e;
        e = (m_rx.size() != 0) ? {24'd0, m_rx[0]} : 32'd0;
        rd(6'h14, d);
        check(req, d, e);
        if (m_rx.size() != 0) void'(m_rx.pop_front());
        m_eval();
    endtask

    task automatic stat_chk(input string req);
        logic [31:0] d;
        rd(6'h04, d);
        check(req, d, exp_stat());
        #1 check({req, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    task automatic stat_clr(input logic [31:0] d);
        wr(6'h04, d);
        if (d[14]) m_don = 0;
        if (d[13]) m_rxt = 0;
        if (d[11]) m_txt = 0;
        m_eval();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, d); check("R1 mode", d, 32'h0);
        rd(6'h08, d); check("R1 mask", d, 32'h0);
        rd(6'h04, d); check("R1 status", d, 32'h0000_8100);
        check("R1 outputs", {29'd0, irq, ctl_en, ctl_loop}, 32'd0);

        // R2 mode fields
        mode_wr(32'hC000_1F0F);
        rd(6'h00, d); check("R2 readback", d, 32'hC000_1F0F);
        check("R2 en/loop pins", {30'd0, ctl_en, ctl_loop}, 32'd3);
        mode_wr(32'hFFFF_FFFF);
        rd(6'h00, d); check("R2 unused bits zero", d, 32'hC000_3F1F);
        mode_wr(32'h8000_1010);
        check("R2 loop off", {31'd0, ctl_loop}, 32'd0);

        // R11 unmapped / port reads
        rd(6'h0C, d); check("R11 unmapped read", d, 32'h0);
        rd(6'h10, d); check("R11 tx port read", d, 32'h0);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h14, 32'hFFFF_FFFF);
        rd(6'h00, d); check("R11 mode kept", d, 32'h8000_1010);
        rd(6'h08, d); check("R11 mask kept", d, 32'h0);
        stat_chk("R11 status kept");

        // R6 enable with empty queue sets TXT; clear all stickies
        check("R6 txt on enable", {31'd0, m_txt}, 32'd1);
        stat_chk("R6 status after enable");
        stat_clr(32'hFFFF_FFFF);
        stat_chk("R8 cleared, live kept");

        // R3 fill transmit queue past full
        for (int i = 0; i < DEPTH + 1; i++) tx_push(8'(i * 7 + 3));
        stat_chk("R3 R5 tx full");
        stat_clr(32'h0000_0800);
        for (int i = 0; i < DEPTH; i++) eng_pop("R3 order");
        eng_pop("R3 empty no valid");
        stat_chk("R6 txt after drain");

        // R4 fill receive queue past full
        for (int i = 0; i < DEPTH + 1; i++) eng_push(8'(255 - i * 5));
        stat_chk("R4 R5 rx full");
        check("R6 rxt set", {31'd0, m_rxt}, 32'd1);
        stat_clr(32'h0000_2000);
        stat_chk("R6 rxt stays clear while above");
        for (int i = 0; i < DEPTH; i++) rx_read("R4 order");
        rx_read("R4 empty read zero");
        stat_chk("R4 empty after underflow");

        // R7 / R8 done and write-1-to-clear
        pulse_done();
        stat_chk("R7 done set");
        stat_clr(32'h0);
        stat_chk("R8 zero write keeps");
        stat_clr(32'h0000_4000);
        stat_chk("R8 done cleared");

        // R9 mask and interrupt
        wr(6'h08, 32'hFFFF_FFFF); m_mask = 8'hFF;
        rd(6'h08, d); check("R9 mask readback", d, 32'h0000_FF00);
        stat_chk("R9 irq all");
        wr(6'h08, 32'h0000_4000); m_mask = 8'h40;
        stat_chk("R9 irq don masked off");
        pulse_done();
        stat_chk("R9 irq don");
        stat_clr(32'h0000_4000);
        stat_chk("R9 irq cleared");

        // R10 disable flushes and gates inputs
        tx_push(8'h11); tx_push(8'h22); eng_push(8'h33); pulse_done();
        mode_wr(32'h0000_1010);
        stat_chk("R10 flushed");
        tx_push(8'h44); eng_push(8'h55); pulse_done();
        rd(6'h04, d); check("R10 ignored while off", d, 32'h0000_8100);
        #1 check("R10 no tx valid", {31'd0, eng_tx_valid}, 32'd0);
        mode_wr(32'h8000_0804);
        stat_chk("R10 R6 re-enable");

        // random traffic
        for (int it = 0; it < 800; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1: tx_push(8'($urandom));
                2:    eng_pop("R3 random pop");
                3, 4: eng_push(8'($urandom));
                5:    rx_read("R4 random read");
                6:    stat_chk("R5 random status");
                7:    stat_clr({16'd0, 8'($urandom), 8'd0});
                8:    pulse_done();
                default: begin
                    if ($urandom_range(0, 1) == 1) begin
                        logic [7:0] mk;
                        mk = 8'($urandom);
                        wr(6'h08, {16'd0, mk, 8'd0}); m_mask = mk;
                    end else begin
                        mode_wr({1'b1, 17'd0, 6'($urandom_range(0, 40)), 3'd0,
                                 5'($urandom_range(0, 31))});
                    end
                    stat_chk("R6 R9 random cfg");
                end
            endcase
        end
        stat_chk("R5 final status");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule